// File: doc/BRIEF.md
# Two-Port Pin Change Interrupt Generator

This block watches two independent 8-bit general-purpose I/O ports and drives one shared interrupt request. The request models an open-drain, active-low line: the output `irq_pd_en_o` is the enable of the pull-down transistor, so a 1 means the line is pulled low (interrupt active) and a 0 means it is released. Every pin first passes through a two-flop synchronizer, and only the synchronized values are compared or returned.

Each port keeps a reference snapshot. A read strobe for a port returns that port's synchronized pin values and copies the same values into its snapshot. The interrupt is level-based: it is active while any pin whose direction bit marks it as an input differs from its port's snapshot. It therefore withdraws by itself when the pin returns to its old level, and a read of one port removes only that port's share of the condition. A pin driven as an output is ignored. A pin that changes from output to input while its level differs from the snapshot raises a spurious interrupt.

Top module: `port_change_irq`

## Requirements
- R1: While `rst_n` is low the interrupt is released (`irq_pd_en_o` = 0), and each snapshot is loaded with its port's synchronized pins, so after reset no interrupt appears for pins that have been steady through reset.
- R2: A change on an input pin (direction bit 1) that makes it differ from its snapshot sets `irq_pd_en_o` to 1 on the third rising clock edge after the change (two synchronizer stages and one output register), and not before.
- R3: When the pin returns to its snapshot level, with no read, `irq_pd_en_o` returns to 0 on the third rising edge after the return.
- R4: While a port's read strobe is high, that port's data output equals its synchronized pins. On the rising edge where the strobe is sampled, the snapshot takes those values, and `irq_pd_en_o` drops to 0 on that same edge if no other input pin differs from its snapshot.
- R5: A read of port 0 leaves a mismatch on port 1 active, and a read of port 1 leaves a mismatch on port 0 active.
- R6: A pin whose direction bit is 0 (output) never raises the interrupt, whatever its level.
- R7: Changing a direction bit from 0 to 1 while that pin differs from its snapshot bit raises the interrupt on the next rising edge.
- R8: After a read, a later change on an input pin raises the interrupt again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin0_i | input | 8 | Asynchronous pin levels of port 0 |
| pin1_i | input | 8 | Asynchronous pin levels of port 1 |
| dir0_i | input | 8 | Direction of port 0 pins, 1 = input |
| dir1_i | input | 8 | Direction of port 1 pins, 1 = input |
| rd0_i | input | 1 | Read strobe of port 0 |
| rd1_i | input | 1 | Read strobe of port 1 |
| rd0_data_o | output | 8 | Synchronized port 0 pins returned by a read |
| rd1_data_o | output | 8 | Synchronized port 1 pins returned by a read |
| irq_pd_en_o | output | 1 | Interrupt pull-down enable, 1 = line driven low |

## Verification
A vector table steps through pin and direction patterns: a single-bit change and its return, which separates level behaviour from a latched flag. It also covers reads of one port while the other port is still pending, which separates per-port clearing from a global clear, and levels toggled on output pins, which show the direction mask is applied. Direction flips from output to input on pins at a stale level check the spurious-interrupt case. Directed tests then time the three-edge latency on both edges of the request and confirm that a reset with new pin levels leaves the request released.

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin0_i,
  input  logic [W-1:0] pin1_i,
  input  logic [W-1:0] dir0_i,
  input  logic [W-1:0] dir1_i,
  input  logic         rd0_i,
  input  logic         rd1_i,
  output logic [W-1:0] rd0_data_o,
  output logic [W-1:0] rd1_data_o,
  output logic         irq_pd_en_o
);

  localparam int NP = 2;

  logic [W-1:0] pin_a [NP];
  logic [W-1:0] dir_a [NP];
  logic [W-1:0] sy_a  [NP];
  logic [NP-1:0] rd_a;
  logic [NP-1:0] mism;
  logic irq_q;

  assign pin_a[0] = pin0_i;
  assign pin_a[1] = pin1_i;
  assign dir_a[0] = dir0_i;
  assign dir_a[1] = dir1_i;
  assign rd_a     = {rd1_i, rd0_i};

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [W-1:0] meta, sy, snap, ref_v;

    always_ff @(posedge clk) begin
      meta <= pin_a[p];
      sy   <= meta;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || rd_a[p]) snap <= sy;
    end

    // a read compares against the value it is about to store
    assign ref_v   = rd_a[p] ? sy : snap;
    assign mism[p] = |((sy ^ ref_v) & dir_a[p]);
    assign sy_a[p] = sy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |mism;
  end

  assign rd0_data_o  = sy_a[0];
  assign rd1_data_o  = sy_a[1];
  assign irq_pd_en_o = irq_q;

  a_r1_reset_release: assert property (@(posedge clk)
    !rst_n |=> !irq_pd_en_o);

  a_r6_outputs_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dir0_i == '0 && dir1_i == '0) |=> !irq_pd_en_o);

  a_r4_read_both_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_i && rd1_i) |=> !irq_pd_en_o);

  a_r5_read0_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_i && !mism[1]) |=> !irq_pd_en_o);

  a_r5_read1_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_i && !mism[0]) |=> !irq_pd_en_o);

  a_r2_needs_input_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pd_en_o |-> $past(|dir0_i || |dir1_i));

endmodule

// File: tb/port_change_irq_bench.sv
module port_change_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  // {pin0, pin1, dir0, dir1, rd1, rd0, irq before read, irq after}
  localparam logic [35:0] VEC [NV] = '{
    {8'h01, 8'h00, 8'hFF, 8'hFF, 2'b00, 1'b1, 1'b1},  // R2
    {8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00, 1'b0, 1'b0},  // R3
    {8'h10, 8'h00, 8'hFF, 8'hFF, 2'b01, 1'b1, 1'b0},  // R4
    {8'h10, 8'h80, 8'hFF, 8'hFF, 2'b01, 1'b1, 1'b1},  // R5
    {8'h10, 8'h80, 8'hFF, 8'hFF, 2'b10, 1'b1, 1'b0},  // R4
    {8'h13, 8'h80, 8'hFC, 8'hFF, 2'b00, 1'b0, 1'b0},  // R6
    {8'h13, 8'h80, 8'hFF, 8'hFF, 2'b00, 1'b1, 1'b1},  // R7
    {8'h13, 8'h80, 8'hFF, 8'hFF, 2'b11, 1'b1, 1'b0},  // R4
    {8'h13, 8'h00, 8'hFF, 8'h00, 2'b00, 1'b0, 1'b0},  // R6
    {8'h13, 8'h00, 8'hFF, 8'hFF, 2'b00, 1'b1, 1'b1},  // R7
    {8'h13, 8'h00, 8'hFF, 8'hFF, 2'b10, 1'b1, 1'b0},  // R5
    {8'h12, 8'h00, 8'hFF, 8'hFF, 2'b00, 1'b1, 1'b1},  // R8
    {8'h12, 8'h00, 8'hFF, 8'hFF, 2'b01, 1'b1, 1'b0}   // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pin0 = '0, pin1 = '0, dir0 = 8'hFF, dir1 = 8'hFF;
  logic rd0 = 1'b0, rd1 = 1'b0;
  logic [7:0] rd0_data, rd1_data;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_change_irq u_port_change_irq (
    .clk(clk), .rst_n(rst_n),
    .pin0_i(pin0), .pin1_i(pin1), .dir0_i(dir0), .dir1_i(dir1),
    .rd0_i(rd0), .rd1_i(rd1),
    .rd0_data_o(rd0_data), .rd1_data_o(rd1_data),
    .irq_pd_en_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    wait_edges(5);
    rst_n = 1'b1;
    wait_edges(2);
    chk("R1 no irq after reset", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      pin0 = v[35:28]; pin1 = v[27:20]; dir0 = v[19:12]; dir1 = v[11:4];
      wait_edges(3);
      chk($sformatf("R2/R6/R7 vec %0d irq before read", i), {7'd0, irq}, {7'd0, v[1]});
      if (v[2]) begin
        rd0 = 1'b1;
        #1 chk($sformatf("R4 vec %0d port0 read data", i), rd0_data, v[35:28]);
      end
      if (v[3]) begin
        rd1 = 1'b1;
        #1 chk($sformatf("R4 vec %0d port1 read data", i), rd1_data, v[27:20]);
      end
      wait_edges(1);
      rd0 = 1'b0; rd1 = 1'b0;
      chk($sformatf("R4/R5/R8 vec %0d irq after", i), {7'd0, irq}, {7'd0, v[0]});
    end

    // R2 latency: port1 bit 0 rises against snapshot 00
    pin1 = 8'h01;
    wait_edges(2);
    chk("R2 not before third edge", {7'd0, irq}, 8'h00);
    wait_edges(1);
    chk("R2 set on third edge", {7'd0, irq}, 8'h01);
    // R3 latency on return
    pin1 = 8'h00;
    wait_edges(2);
    chk("R3 held before third edge", {7'd0, irq}, 8'h01);
    wait_edges(1);
    chk("R3 withdrawn on third edge", {7'd0, irq}, 8'h00);

    // R1 reset with new pin levels
    pin0 = 8'hA5; pin1 = 8'h3C;
    rst_n = 1'b0;
    wait_edges(4);
    chk("R1 released in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    wait_edges(3);
    chk("R1 snapshot loaded in reset", {7'd0, irq}, 8'h00);
    chk("R1 port0 data", rd0_data, 8'hA5);
    chk("R1 port1 data", rd1_data, 8'h3C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule